// File: doc/BRIEF.md
# Multi-Level Cell Program-Verify Code Register

This block belongs to one column of a multi-level cell array. A short target code arrives on the shared column bus and is captured into a holding register when the column is addressed. A transfer places that code into a full-width working register. The code fills the upper bits, and a centring pattern of a single one followed by zeros fills the lower bits. The working value then serves as the program-verify target. After each small wordline step the array senses the cell and presents a full-width result with a valid strobe. Once a result reaches the target, the block raises an inhibit that keeps the bitline high. A bounded number of failing senses ends the attempt with a fail flag instead.

When the block is idle, the working register can act as a plain counter stage. In the same state, a valid sense result is read back. Its upper bits become the short code, so noise in the lower bits does not change the result. The addressed column drives that code onto the bus through an output enable.

The controller has four states: `ST_IDLE`, `ST_PROG`, `ST_DONE` and `ST_FAIL`.

| Transition | From | To | Condition |
|---|---|---|---|
| start | `ST_IDLE` | `ST_PROG` | a transfer |
| pass | `ST_PROG` | `ST_DONE` | a valid sense at or above the target |
| timeout | `ST_PROG` | `ST_FAIL` | the last allowed failing sense |
| clear | any state | `ST_IDLE` | a selected store |

Top module: `pv_code_reg`

## Requirements
- R1: After reset the state is `ST_IDLE`, the working word and held code are zero, the read-back code is zero, and inhibit, done and fail are low.
- R2: A store while the column is selected (address enable high and column address equal to `COL_ID`) captures the bus code into the holding register. It returns the block to `ST_IDLE` and clears inhibit, done and fail on the next cycle. A store without that selection has no effect.
- R3: A transfer without a selected store swaps the two registers. The working word becomes the held code in its upper `CODE_W` bits with the centring pattern below it; for 5-bit codes in 8 bits, code 10110 gives 10110100. The held code becomes the previous upper `CODE_W` bits of the working word. A transfer in `ST_IDLE` enters `ST_PROG` and zeroes the step count.
- R4: In `ST_IDLE`, with count high and neither store nor transfer active, the working word increments by one, modulo 2^`SENSE_W`.
- R5: In `ST_PROG`, a valid sense result greater than or equal to the working word moves the block to `ST_DONE`. Done and inhibit go high on the next cycle. Done and fail are never high together.
- R6: In `ST_PROG`, each valid sense result below the working word counts one step. The `MAX_STEPS`-th such step moves the block to `ST_FAIL`, and fail and inhibit go high on the next cycle. Earlier failing steps leave it in `ST_PROG`.
- R7: Inhibit, once high, stays high through sense strobes, transfers and counts until a selected store.
- R8: In `ST_IDLE`, a valid sense result loads its upper `CODE_W` bits into the read-back code, so every result sharing those bits reads back the same code. In other states the read-back code is unchanged.
- R9: The bus output enable is high exactly when the column is selected and read enable is high. The bus read data then equals the read-back code, and it is zero otherwise.
- R10: Outside `ST_IDLE`, count has no effect on the working word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| store_i | input | 1 | Capture the bus code (needs selection) |
| xfer_i | input | 1 | Swap the holding and working registers |
| count_i | input | 1 | Increment the working word while idle |
| addr_en_i | input | 1 | Column address enable |
| col_addr_i | input | COL_W | Column address on the bus |
| rd_en_i | input | 1 | Request read-back onto the bus |
| bus_wdata_i | input | CODE_W | Short code from the bus |
| bus_rdata_o | output | CODE_W | Read-back code toward the bus |
| bus_oe_o | output | 1 | Tristate enable for the bus driver |
| sense_i | input | SENSE_W | Full-width sense result |
| sense_vld_i | input | 1 | Sense result strobe |
| work_o | output | SENSE_W | Working word (target or count) |
| inhibit_o | output | 1 | Hold bitline high, no more pulses |
| done_o | output | 1 | Cell reached its target |
| fail_o | output | 1 | Step limit reached without passing |

## Verification
The bench presents a sense result exactly equal to the target. A strict comparison would let the cell keep receiving pulses, and the bench would see inhibit stay low. It runs exactly `MAX_STEPS` failing senses and checks the cycle before the last one. An off-by-one step counter would raise fail one strobe early or late. It also sends transfers and strobes after completion, which a design that drops inhibit would expose. Finally, it reads back sense words with the lowest and highest lower bits under one code and issues a store to a foreign column. A decoder that rounds, or a store that ignores the address, would change the observed code or working word.

// File: rtl/pvc_pkg.sv
package pvc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PROG = 2'd1,
        ST_DONE = 2'd2,
        ST_FAIL = 2'd3
    } pv_state_t;
endpackage

// File: rtl/pvc_code_regs.sv
module pvc_code_regs #(
    parameter int CODE_W  = 5,
    parameter int SENSE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [CODE_W-1:0]  code_i,
    input  logic               xfer_i,
    input  logic               cnt_i,
    output logic [SENSE_W-1:0] work_o
);
    localparam int PAD_W = SENSE_W - CODE_W;
    localparam logic [PAD_W-1:0] CENTER = PAD_W'(1) << (PAD_W - 1);

    logic [CODE_W-1:0] hold_q;
    logic [SENSE_W-1:0] work_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            work_q <= '0;
        end else if (load_i) begin
            hold_q <= code_i;
        end else if (xfer_i) begin
            work_q <= {hold_q, CENTER};
            hold_q <= work_q[SENSE_W-1 -: CODE_W];
        end else if (cnt_i) begin
            work_q <= work_q + 1'b1;
        end
    end

    assign work_o = work_q;
endmodule

// File: rtl/pvc_fsm.sv
module pvc_fsm
    import pvc_pkg::*;
#(
    parameter int MAX_STEPS = 6
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr_i,
    input  logic      start_i,
    input  logic      vld_i,
    input  logic      pass_i,
    output pv_state_t state_o,
    output logic      inhibit_o,
    output logic      done_o,
    output logic      fail_o
);
    localparam int STEP_W = $clog2(MAX_STEPS + 1);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(MAX_STEPS - 1);

    pv_state_t state_q, state_d;
    logic [STEP_W-1:0] steps_q, steps_d;

    always_comb begin
        state_d = state_q;
        steps_d = steps_q;
        if (clr_i) begin
            state_d = ST_IDLE;
            steps_d = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    state_d = ST_PROG;
                    steps_d = '0;
                end
                ST_PROG: if (vld_i) begin
                    if (pass_i) begin
                        state_d = ST_DONE;
                    end else if (steps_q == LAST) begin
                        state_d = ST_FAIL;
                    end else begin
                        steps_d = steps_q + 1'b1;
                    end
                end
                ST_DONE: state_d = ST_DONE;
                ST_FAIL: state_d = ST_FAIL;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            steps_q <= '0;
        end else begin
            state_q <= state_d;
            steps_q <= steps_d;
        end
    end

    always_comb begin
        inhibit_o = 1'b0;
        done_o    = 1'b0;
        fail_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PROG: ;
            ST_DONE: begin
                inhibit_o = 1'b1;
                done_o    = 1'b1;
            end
            ST_FAIL: begin
                inhibit_o = 1'b1;
                fail_o    = 1'b1;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/pvc_readout.sv
module pvc_readout #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [CODE_W-1:0] upper_i,
    input  logic              sel_i,
    input  logic              rd_en_i,
    output logic [CODE_W-1:0] bus_rdata_o,
    output logic              bus_oe_o
);
    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (cap_i) begin
            code_q <= upper_i;
        end
    end

    assign bus_oe_o    = sel_i & rd_en_i;
    assign bus_rdata_o = bus_oe_o ? code_q : '0;
endmodule

// File: rtl/pv_code_reg.sv
module pv_code_reg
    import pvc_pkg::*;
#(
    parameter int CODE_W    = 5,
    parameter int SENSE_W   = 8,
    parameter int COL_W     = 4,
    parameter int COL_ID    = 5,
    parameter int MAX_STEPS = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               store_i,
    input  logic               xfer_i,
    input  logic               count_i,
    input  logic               addr_en_i,
    input  logic [COL_W-1:0]   col_addr_i,
    input  logic               rd_en_i,
    input  logic [CODE_W-1:0]  bus_wdata_i,
    output logic [CODE_W-1:0]  bus_rdata_o,
    output logic               bus_oe_o,
    input  logic [SENSE_W-1:0] sense_i,
    input  logic               sense_vld_i,
    output logic [SENSE_W-1:0] work_o,
    output logic               inhibit_o,
    output logic               done_o,
    output logic               fail_o
);
    localparam logic [COL_W-1:0] MY_COL = COL_W'(COL_ID);

    pv_state_t state;
    logic sel, load, idle, pass;

    assign sel  = addr_en_i && (col_addr_i == MY_COL);
    assign load = store_i && sel;
    assign idle = (state == ST_IDLE);
    assign pass = (sense_i >= work_o);

    pvc_code_regs #(.CODE_W(CODE_W), .SENSE_W(SENSE_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .code_i (bus_wdata_i),
        .xfer_i (xfer_i),
        .cnt_i  (count_i && idle),
        .work_o (work_o)
    );

    pvc_fsm #(.MAX_STEPS(MAX_STEPS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (load),
        .start_i   (xfer_i),
        .vld_i     (sense_vld_i),
        .pass_i    (pass),
        .state_o   (state),
        .inhibit_o (inhibit_o),
        .done_o    (done_o),
        .fail_o    (fail_o)
    );

    pvc_readout #(.CODE_W(CODE_W)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_i       (sense_vld_i && idle && !load),
        .upper_i     (sense_i[SENSE_W-1 -: CODE_W]),
        .sel_i       (sel),
        .rd_en_i     (rd_en_i),
        .bus_rdata_o (bus_rdata_o),
        .bus_oe_o    (bus_oe_o)
    );
endmodule

// File: rtl/pvc_checker.sv
module pvc_checker #(
    parameter int CODE_W  = 5,
    parameter int SENSE_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               store_sel,
    input logic               xfer_i,
    input logic               count_i,
    input logic               addr_en_i,
    input logic               rd_en_i,
    input logic               sense_vld_i,
    input logic               bus_oe_o,
    input logic [1:0]         state,
    input logic [SENSE_W-1:0] work_o,
    input logic               inhibit_o,
    input logic               done_o,
    input logic               fail_o
);
    localparam int PAD_W = SENSE_W - CODE_W;
    localparam logic [PAD_W-1:0] CENTER = PAD_W'(1) << (PAD_W - 1);

    p_store_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        store_sel |=> !inhibit_o && !done_o && !fail_o);
    p_xfer_center_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_i && !store_sel |=> work_o[PAD_W-1:0] == CENTER);
    p_count_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count_i && !xfer_i && !store_sel && state == 2'd0
        |=> work_o == SENSE_W'($past(work_o) + 1'b1));
    p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));
    p_done_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(sense_vld_i));
    p_fail_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_o) |-> $past(sense_vld_i));
    p_inhibit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_o && !store_sel |=> inhibit_o);
    p_oe_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> addr_en_i && rd_en_i);
    p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state != 2'd0 && !xfer_i && !store_sel |=> $stable(work_o));
endmodule

bind pv_code_reg pvc_checker #(.CODE_W(CODE_W), .SENSE_W(SENSE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .store_sel   (load),
    .xfer_i      (xfer_i),
    .count_i     (count_i),
    .addr_en_i   (addr_en_i),
    .rd_en_i     (rd_en_i),
    .sense_vld_i (sense_vld_i),
    .bus_oe_o    (bus_oe_o),
    .state       (state),
    .work_o      (work_o),
    .inhibit_o   (inhibit_o),
    .done_o      (done_o),
    .fail_o      (fail_o)
);

// File: tb/sim_pv_code_reg.sv
`timescale 1ns/1ps
module sim_pv_code_reg;
    localparam int CW = 5, SW = 8, AW = 4, MYC = 5, MAXS = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic store_i = 0, xfer_i = 0, count_i = 0, addr_en_i = 0, rd_en_i = 0, sense_vld_i = 0;
    logic [AW-1:0] col_addr_i = '0;
    logic [CW-1:0] bus_wdata_i = '0;
    logic [SW-1:0] sense_i = '0;
    logic [CW-1:0] bus_rdata_o;
    logic bus_oe_o, inhibit_o, done_o, fail_o;
    logic [SW-1:0] work_o;

    always #10 clk = ~clk;

    pv_code_reg #(.CODE_W(CW), .SENSE_W(SW), .COL_W(AW), .COL_ID(MYC), .MAX_STEPS(MAXS)) u0 (
        .clk(clk), .rst_n(rst_n), .store_i(store_i), .xfer_i(xfer_i), .count_i(count_i),
        .addr_en_i(addr_en_i), .col_addr_i(col_addr_i), .rd_en_i(rd_en_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .bus_oe_o(bus_oe_o),
        .sense_i(sense_i), .sense_vld_i(sense_vld_i), .work_o(work_o),
        .inhibit_o(inhibit_o), .done_o(done_o), .fail_o(fail_o));

    // behavioural model: 0 idle, 1 programming, 2 passed, 3 failed
    int m_hold = 0, m_work = 0, m_st = 0, m_steps = 0, m_rd = 0;
    int n_chk = 0, n_err = 0;

    always @(posedge clk) begin
        int ow, os;
        bit sel;
        ow = m_work; os = m_st;
        sel = addr_en_i && (int'(col_addr_i) == MYC);
        if (!rst_n) begin
            m_hold = 0; m_work = 0; m_st = 0; m_steps = 0; m_rd = 0;
        end else if (store_i && sel) begin
            m_hold = int'(bus_wdata_i); m_st = 0; m_steps = 0;
        end else begin
            if (xfer_i) begin
                m_work = m_hold * 8 + 4;
                m_hold = ow / 8;
            end else if (count_i && os == 0) begin
                m_work = (ow + 1) % 256;
            end
            if (os == 0 && sense_vld_i) m_rd = int'(sense_i) / 8;
            if (os == 0 && xfer_i) begin
                m_st = 1; m_steps = 0;
            end else if (os == 1 && sense_vld_i) begin
                if (int'(sense_i) >= ow) m_st = 2;
                else if (m_steps == MAXS - 1) m_st = 3;
                else m_steps = m_steps + 1;
            end
        end
    end

    task automatic check(input string tag);
        bit sel, eo;
        int erd;
        sel = addr_en_i && (int'(col_addr_i) == MYC);
        eo = sel && rd_en_i;
        erd = eo ? m_rd : 0;
        n_chk++;
        if (int'(work_o) != m_work || inhibit_o != (m_st >= 2) || done_o != (m_st == 2) ||
            fail_o != (m_st == 3) || bus_oe_o != eo || int'(bus_rdata_o) != erd) begin
            n_err++;
            $display("FAIL %s: got work=%0d inh=%0b done=%0b fail=%0b oe=%0b rd=%0d exp work=%0d st=%0d oe=%0b rd=%0d",
                     tag, work_o, inhibit_o, done_o, fail_o, bus_oe_o, bus_rdata_o, m_work, m_st, eo, erd);
        end
    endtask

    task automatic expect_val(input int got, input int exp, input string tag);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic cyc(input bit st, input bit xf, input bit cn, input bit ae, input int ca,
                       input bit re, input int wd, input int sn, input bit sv, input string tag);
        @(negedge clk);
        store_i = st; xfer_i = xf; count_i = cn; addr_en_i = ae; col_addr_i = AW'(ca);
        rd_en_i = re; bus_wdata_i = CW'(wd); sense_i = SW'(sn); sense_vld_i = sv;
        #2 check(tag);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #4000000;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset");
        expect_val(int'(work_o), 0, "R1 work");
        expect_val(int'(inhibit_o), 0, "R1 inhibit");

        // foreign column store ignored, then selected store of 10110
        cyc(1, 0, 0, 1, 3, 0, 5'b01111, 0, 0, "R2 foreign");
        cyc(1, 0, 0, 1, MYC, 0, 5'b10110, 0, 0, "R2 store");
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, "R3 xfer");
        idle("R3 target");
        expect_val(int'(work_o), 8'b10110100, "R3 centred");

        // below, below, equal -> pass
        cyc(0, 0, 1, 0, 0, 0, 0, 8'b10110011, 1, "R6 below");
        cyc(0, 0, 0, 0, 0, 0, 0, 8'b10101111, 1, "R10 count ignored");
        cyc(0, 0, 0, 0, 0, 0, 0, 8'b10110100, 1, "R5 equal");
        idle("R5 done");
        expect_val(int'(done_o), 1, "R5 done");
        expect_val(int'(inhibit_o), 1, "R5 inhibit");

        // inhibit held through strobes and transfer back
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R7 strobe");
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, "R7 xfer back");
        cyc(1, 0, 0, 1, 2, 0, 0, 0, 0, "R7 foreign store");
        idle("R7 still");
        expect_val(int'(inhibit_o), 1, "R7 held");

        // clear, swap again: held code came back
        cyc(1, 0, 0, 1, MYC, 0, 5'b00011, 0, 0, "R2 clear");
        idle("R2 cleared");
        expect_val(int'(inhibit_o), 0, "R2 inhibit low");
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, "R3 swap");
        cyc(1, 0, 0, 1, MYC, 0, 0, 0, 0, "R2 reidle");
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, "R4 count");
        idle("R4 counted");
        expect_val(int'(work_o), 8'b00011100 + 3, "R4 value");

        // counter wrap in idle
        cyc(1, 0, 0, 1, MYC, 0, 5'b11111, 0, 0, "R2 store max");
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, "R3 xfer max");
        cyc(1, 0, 0, 1, MYC, 0, 5'b11111, 0, 0, "R2 back idle");
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, "R4 wrap");
        idle("R4 wrapped");
        expect_val(int'(work_o), 0, "R4 wrap");

        // fail after MAXS failing senses
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, "R6 start");
        for (int i = 0; i < MAXS - 1; i++) cyc(0, 0, 0, 0, 0, 0, 0, i, 1, "R6 step");
        idle("R6 before last");
        expect_val(int'(fail_o), 0, "R6 not yet");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, "R6 last");
        idle("R6 failed");
        expect_val(int'(fail_o), 1, "R6 fail");
        expect_val(int'(done_o), 0, "R5 exclusive");

        // read path
        cyc(1, 0, 0, 1, MYC, 0, 0, 0, 0, "R2 to idle");
        cyc(0, 0, 0, 0, 0, 0, 0, 8'b10110000, 1, "R8 low noise");
        cyc(0, 0, 0, 1, MYC, 1, 0, 0, 0, "R9 read");
        expect_val(int'(bus_rdata_o), 5'b10110, "R8 code");
        cyc(0, 0, 0, 0, 0, 0, 0, 8'b10110111, 1, "R8 high noise");
        cyc(0, 0, 0, 1, MYC, 1, 0, 0, 0, "R9 read2");
        expect_val(int'(bus_rdata_o), 5'b10110, "R8 same code");
        cyc(0, 0, 0, 1, 4, 1, 0, 0, 0, "R9 other column");
        expect_val(int'(bus_oe_o), 0, "R9 no drive");
        cyc(0, 0, 0, 0, MYC, 1, 0, 0, 0, "R9 no enable");
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, "R8 enter prog");
        cyc(0, 0, 0, 0, 0, 0, 0, 8'b00001000, 1, "R8 prog sense");
        cyc(0, 0, 0, 1, MYC, 1, 0, 0, 0, "R8 unchanged");
        expect_val(int'(bus_rdata_o), 5'b10110, "R8 kept");
        idle("end");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule